// File: doc/BRIEF.md
# Handle-Bound Opcode Redirect Table

This block binds a small set of generic three-register opcodes to extension engines at run time. It holds one slot per generic function number, and each slot holds a 128-bit unique identifier. An open operation writes an identifier into a chosen slot, and a close operation returns that slot to the invalid value (all ones).

When one of the generic opcodes is issued with function number N, the block reads slot N. It compares the slot against the fixed identifiers of the extensions attached at elaboration time. It then hands the operand bundle to the one engine whose identifier matches. If no engine matches, the block signals an illegal instruction instead.

The decoder in front of the block and the extension engines behind it are separate blocks. The register-file side supplies the operands and the destination tag, and the engines consume the registered dispatch bundle.

Top module: `opc_redirect`

## Requirements
- R1: After reset every slot holds the invalid value (all ones), so any issue before an open results in `exc_illegal` and no `ext_valid` bit.
- R2: When `cfg_valid`=1 and `cfg_open`=1, `cfg_id` is written into slot `cfg_slot`. A later issue with `iss_fn`=`cfg_slot` then sets `ext_valid` bit e, where e is the extension whose identifier equals bits [e*128 +: 128] of `EXT_IDS`.
- R3: With a dispatch or exception, `ext_fn`, `ext_opa`, `ext_opb` and `ext_dst` equal the `iss_fn`, `iss_opa`, `iss_opb` and `iss_dst` of the issue that caused it, unchanged.
- R4: When `cfg_valid`=1 and `cfg_open`=0, slot `cfg_slot` is set to all ones, and later issues of that function number raise `exc_illegal`.
- R5: An issue whose slot holds an identifier equal to no attached extension raises `exc_illegal` and sets no `ext_valid` bit.
- R6: At most one `ext_valid` bit is set in any cycle, and `exc_illegal` is never set together with any `ext_valid` bit.
- R7: An open or close in the same cycle as an issue reading the same slot does not affect that issue. The issue uses the slot value from before the write, and the write applies from the next issue on.
- R8: An open or close whose `cfg_slot` is 8 or above (4-bit field) changes no slot.
- R9: The response (`ext_valid` or `exc_illegal`) appears in the cycle after `iss_valid` and lasts one cycle. In a cycle after no issue, all `ext_valid` bits and `exc_illegal` are 0.
- R10: A second open of a slot replaces its identifier, so later issues follow the newest binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Open or close request this cycle |
| cfg_open | input | 1 | 1 = open (write identifier), 0 = close (invalidate) |
| cfg_slot | input | 4 | Slot number; values 8 to 15 are ignored |
| cfg_id | input | 128 | Identifier written on open |
| iss_valid | input | 1 | A generic opcode is issued this cycle |
| iss_fn | input | 3 | Function number of the issued opcode |
| iss_opa | input | 32 | First source operand |
| iss_opb | input | 32 | Second source operand |
| iss_dst | input | 5 | Destination register tag |
| ext_valid | output | NUM_EXT (3) | One-hot dispatch strobe, one bit per extension |
| ext_fn | output | 3 | Function number forwarded to the engine |
| ext_opa | output | 32 | First operand forwarded |
| ext_opb | output | 32 | Second operand forwarded |
| ext_dst | output | 5 | Destination tag forwarded |
| exc_illegal | output | 1 | Illegal-instruction strobe |

## Verification
The hardest case to reach from the ports is a write to a slot and an issue reading that same slot in the same cycle. Random traffic seldom lines these up, so directed steps first force a close and an issue on one slot together, and then an open and an issue together. Random traffic then draws slot and function numbers from a narrow range so that the two often coincide. Out-of-range slot numbers that alias onto a live slot in their low bits are also driven on purpose, so that a design that drops the top bit would overwrite a bound slot.

// File: rtl/opc_redirect_pkg.sv
package opc_redirect_pkg;
   localparam int ID_W    = 128;
   localparam int MAX_EXT = 4;

   localparam logic [MAX_EXT*ID_W-1:0] DEF_EXT_IDS = {
      128'h3f1c_88a2_5b07_4e19_a6d3_0c2e_71b4_9d50,
      128'hc42e_7710_0d9a_4b63_8e15_f2a7_3c09_6b84,
      128'h9a05_e3d1_2f6c_47b8_b150_6e2d_d8a3_1f72,
      128'h0b7d_41e6_c829_4a3f_9e01_57c4_2ad8_e613
   };

   typedef enum logic {
      CFG_CLOSE = 1'b0,
      CFG_OPEN  = 1'b1
   } cfg_op_e;
endpackage

// File: rtl/opc_redirect_table.sv
module opc_redirect_table #(
   parameter int NUM_SLOTS = 8,
   parameter int ID_W      = 128,
   localparam int IDX_W    = $clog2(NUM_SLOTS),
   localparam int SLOT_W   = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_open,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ID_W-1:0]   rd_id
);
   localparam logic [ID_W-1:0] INVALID = '1;

   logic [ID_W-1:0] slot_q [NUM_SLOTS];
   logic            in_range;

   assign in_range = (wr_slot < SLOT_W'(NUM_SLOTS));

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit_s;
      assign hit_s = wr_en && in_range && (wr_slot[IDX_W-1:0] == IDX_W'(s));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[s] <= INVALID;
         end else if (hit_s) begin
            slot_q[s] <= wr_open ? wr_id : INVALID;
         end
      end
   end

   // Read sees the pre-write value of a slot written in the same cycle.
   assign rd_id = slot_q[rd_idx];
endmodule

// File: rtl/opc_redirect_match.sv
module opc_redirect_match #(
   parameter int                      NUM_EXT = 3,
   parameter int                      ID_W    = 128,
   parameter logic [4*128-1:0]        EXT_IDS = '0
) (
   input  logic [ID_W-1:0]    id,
   output logic [NUM_EXT-1:0] hit
);
   localparam logic [ID_W-1:0] INVALID = '1;

   logic id_live;
   assign id_live = (id != INVALID);

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_cmp
      localparam logic [ID_W-1:0] MY_ID = EXT_IDS[e*ID_W +: ID_W];
      assign hit[e] = id_live && (id == MY_ID);
   end
endmodule

// File: rtl/opc_redirect_disp.sv
module opc_redirect_disp #(
   parameter int NUM_EXT = 3,
   parameter int FN_W    = 3,
   parameter int OPD_W   = 32,
   parameter int DST_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iss_valid,
   input  logic [NUM_EXT-1:0] hit,
   input  logic [FN_W-1:0]    iss_fn,
   input  logic [OPD_W-1:0]   iss_opa,
   input  logic [OPD_W-1:0]   iss_opb,
   input  logic [DST_W-1:0]   iss_dst,
   output logic [NUM_EXT-1:0] ext_valid,
   output logic [FN_W-1:0]    ext_fn,
   output logic [OPD_W-1:0]   ext_opa,
   output logic [OPD_W-1:0]   ext_opb,
   output logic [DST_W-1:0]   ext_dst,
   output logic               exc_illegal
);
   logic any_hit;
   assign any_hit = |hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_valid   <= '0;
         exc_illegal <= 1'b0;
      end else begin
         ext_valid   <= iss_valid ? hit : '0;
         exc_illegal <= iss_valid && !any_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_fn  <= '0;
         ext_opa <= '0;
         ext_opb <= '0;
         ext_dst <= '0;
      end else if (iss_valid) begin
         ext_fn  <= iss_fn;
         ext_opa <= iss_opa;
         ext_opb <= iss_opb;
         ext_dst <= iss_dst;
      end
   end
endmodule

// File: rtl/opc_redirect.sv
module opc_redirect
   import opc_redirect_pkg::*;
#(
   parameter int                        NUM_SLOTS = 8,
   parameter int                        NUM_EXT   = 3,
   parameter int                        OPD_W     = 32,
   parameter int                        DST_W     = 5,
   parameter logic [MAX_EXT*ID_W-1:0]   EXT_IDS   = DEF_EXT_IDS,
   localparam int                       FN_W      = $clog2(NUM_SLOTS),
   localparam int                       SLOT_W    = FN_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_valid,
   input  logic               cfg_open,
   input  logic [SLOT_W-1:0]  cfg_slot,
   input  logic [ID_W-1:0]    cfg_id,
   input  logic               iss_valid,
   input  logic [FN_W-1:0]    iss_fn,
   input  logic [OPD_W-1:0]   iss_opa,
   input  logic [OPD_W-1:0]   iss_opb,
   input  logic [DST_W-1:0]   iss_dst,
   output logic [NUM_EXT-1:0] ext_valid,
   output logic [FN_W-1:0]    ext_fn,
   output logic [OPD_W-1:0]   ext_opa,
   output logic [OPD_W-1:0]   ext_opb,
   output logic [DST_W-1:0]   ext_dst,
   output logic               exc_illegal
);
   // Elaboration-time parameter checks
   if (NUM_EXT < 1 || NUM_EXT > MAX_EXT) begin : g_bad_ext
      $error("NUM_EXT must lie in 1..%0d", MAX_EXT);
   end
   if (NUM_SLOTS < 2 || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two, at least 2");
   end
   for (genvar a = 0; a < NUM_EXT; a++) begin : g_id_chk
      if (EXT_IDS[a*ID_W +: ID_W] == {ID_W{1'b1}}) begin : g_inv
         $error("extension %0d identifier equals the invalid value", a);
      end
      for (genvar b = a + 1; b < NUM_EXT; b++) begin : g_dup
         if (EXT_IDS[a*ID_W +: ID_W] == EXT_IDS[b*ID_W +: ID_W]) begin : g_same
            $error("extensions %0d and %0d share an identifier", a, b);
         end
      end
   end

   logic [ID_W-1:0]    rd_id;
   logic [NUM_EXT-1:0] hit;

   opc_redirect_table #(
      .NUM_SLOTS (NUM_SLOTS),
      .ID_W      (ID_W)
   ) table_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_valid),
      .wr_open (cfg_open == CFG_OPEN),
      .wr_slot (cfg_slot),
      .wr_id   (cfg_id),
      .rd_idx  (iss_fn),
      .rd_id   (rd_id)
   );

   opc_redirect_match #(
      .NUM_EXT (NUM_EXT),
      .ID_W    (ID_W),
      .EXT_IDS (EXT_IDS)
   ) match_i (
      .id  (rd_id),
      .hit (hit)
   );

   opc_redirect_disp #(
      .NUM_EXT (NUM_EXT),
      .FN_W    (FN_W),
      .OPD_W   (OPD_W),
      .DST_W   (DST_W)
   ) disp_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .iss_valid   (iss_valid),
      .hit         (hit),
      .iss_fn      (iss_fn),
      .iss_opa     (iss_opa),
      .iss_opb     (iss_opb),
      .iss_dst     (iss_dst),
      .ext_valid   (ext_valid),
      .ext_fn      (ext_fn),
      .ext_opa     (ext_opa),
      .ext_opb     (ext_opb),
      .ext_dst     (ext_dst),
      .exc_illegal (exc_illegal)
   );
endmodule

// File: rtl/opc_redirect_chk.sv
module opc_redirect_chk #(
   parameter int NUM_EXT = 3,
   parameter int FN_W    = 3,
   parameter int OPD_W   = 32,
   parameter int DST_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iss_valid,
   input logic [FN_W-1:0]    iss_fn,
   input logic [OPD_W-1:0]   iss_opa,
   input logic [OPD_W-1:0]   iss_opb,
   input logic [DST_W-1:0]   iss_dst,
   input logic [NUM_EXT-1:0] ext_valid,
   input logic [FN_W-1:0]    ext_fn,
   input logic [OPD_W-1:0]   ext_opa,
   input logic [OPD_W-1:0]   ext_opb,
   input logic [DST_W-1:0]   ext_dst,
   input logic               exc_illegal
);
   a_r6_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ext_valid));

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      exc_illegal |-> (ext_valid == '0));

   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid |=> (ext_valid == '0) && !exc_illegal);

   a_r9_answer: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> (ext_valid != '0) || exc_illegal);

   a_r3_bundle: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> (ext_fn == $past(iss_fn)) && (ext_opa == $past(iss_opa))
                    && (ext_opb == $past(iss_opb)) && (ext_dst == $past(iss_dst)));
endmodule

bind opc_redirect opc_redirect_chk #(
   .NUM_EXT (NUM_EXT),
   .FN_W    (FN_W),
   .OPD_W   (OPD_W),
   .DST_W   (DST_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .iss_valid   (iss_valid),
   .iss_fn      (iss_fn),
   .iss_opa     (iss_opa),
   .iss_opb     (iss_opb),
   .iss_dst     (iss_dst),
   .ext_valid   (ext_valid),
   .ext_fn      (ext_fn),
   .ext_opa     (ext_opa),
   .ext_opb     (ext_opb),
   .ext_dst     (ext_dst),
   .exc_illegal (exc_illegal)
);

// File: tb/opc_redirect_tb_top.sv
module opc_redirect_tb_top;
   import opc_redirect_pkg::*;

   localparam int NE  = 3;
   localparam int NS  = 8;
   localparam logic [ID_W-1:0] INV = '1;
   localparam logic [ID_W-1:0] UNKNOWN_ID = 128'h5555_0000_aaaa_1111_2222_3333_4444_6666;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_valid, cfg_open;
   logic [3:0]        cfg_slot;
   logic [ID_W-1:0]   cfg_id;
   logic              iss_valid;
   logic [2:0]        iss_fn;
   logic [31:0]       iss_opa, iss_opb;
   logic [4:0]        iss_dst;
   logic [NE-1:0]     ext_valid;
   logic [2:0]        ext_fn;
   logic [31:0]       ext_opa, ext_opb;
   logic [4:0]        ext_dst;
   logic              exc_illegal;

   always #5 clk = ~clk;

   opc_redirect #(.NUM_SLOTS(NS), .NUM_EXT(NE)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_valid(cfg_valid), .cfg_open(cfg_open), .cfg_slot(cfg_slot), .cfg_id(cfg_id),
      .iss_valid(iss_valid), .iss_fn(iss_fn), .iss_opa(iss_opa), .iss_opb(iss_opb),
      .iss_dst(iss_dst), .ext_valid(ext_valid), .ext_fn(ext_fn), .ext_opa(ext_opa),
      .ext_opb(ext_opb), .ext_dst(ext_dst), .exc_illegal(exc_illegal)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [ID_W-1:0] model [NS];

   function automatic logic [ID_W-1:0] ext_id(int e);
      return DEF_EXT_IDS[e*ID_W +: ID_W];
   endfunction

   function automatic logic [NE-1:0] expect_hit(logic [ID_W-1:0] v);
      logic [NE-1:0] h = '0;
      for (int e = 0; e < NE; e++) if (v != INV && v == ext_id(e)) h[e] = 1'b1;
      return h;
   endfunction

   task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, predict from model, apply edge, compare.
   task automatic step(bit cv, bit op, logic [3:0] sl, logic [ID_W-1:0] id,
                       bit iv, logic [2:0] fn, string tag);
      logic [NE-1:0] ev;
      bit            ex;
      logic [31:0]   a = $urandom;
      logic [31:0]   b = $urandom;
      logic [4:0]    d = 5'($urandom);
      cfg_valid = cv; cfg_open = op; cfg_slot = sl; cfg_id = id;
      iss_valid = iv; iss_fn = fn; iss_opa = a; iss_opb = b; iss_dst = d;
      ev = iv ? expect_hit(model[fn]) : '0;
      ex = iv && (ev == '0);
      if (cv && sl < 4'(NS)) model[sl[2:0]] = op ? id : INV;
      @(negedge clk);
      check(ext_valid == ev, {tag, " ext_valid"}, 128'(ext_valid), 128'(ev));
      check(exc_illegal == ex, {tag, " exc_illegal"}, 128'(exc_illegal), 128'(ex));
      if (iv)
         check({ext_fn, ext_opa, ext_opb, ext_dst} == {fn, a, b, d},
               {tag, " R3 bundle"}, 128'({ext_fn, ext_opa, ext_opb, ext_dst}),
               128'({fn, a, b, d}));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d5e_0b07));
      rst_n = 0; cfg_valid = 0; cfg_open = 0; cfg_slot = 0; cfg_id = '0;
      iss_valid = 0; iss_fn = 0; iss_opa = 0; iss_opb = 0; iss_dst = 0;
      for (int s = 0; s < NS; s++) model[s] = INV;
      repeat (3) @(negedge clk);
      check(ext_valid == '0, "R1 reset ext_valid", 128'(ext_valid), 0);
      check(!exc_illegal, "R1 reset exc_illegal", 128'(exc_illegal), 0);
      rst_n = 1;
      for (int f = 0; f < NS; f++) step(0, 0, 0, '0, 1, 3'(f), "R1 fresh slot");
      step(0, 0, 0, '0, 0, 0, "R9 idle");
      step(1, 1, 4'd2, ext_id(1), 0, 0, "R2 open");
      step(0, 0, 0, '0, 1, 3'd2, "R2 dispatch");
      step(1, 0, 4'd2, '0, 1, 3'd2, "R7 close with issue");
      step(0, 0, 0, '0, 1, 3'd2, "R4 closed");
      step(1, 1, 4'd6, ext_id(2), 1, 3'd6, "R7 open with issue");
      step(0, 0, 0, '0, 1, 3'd6, "R2 after open");
      step(1, 1, 4'd9, ext_id(0), 0, 0, "R8 slot 9");
      step(1, 0, 4'd14, '0, 1, 3'd1, "R8 check slot 1");
      step(0, 0, 0, '0, 1, 3'd6, "R8 slot 6 kept");
      step(1, 1, 4'd5, UNKNOWN_ID, 0, 0, "R5 open unknown");
      step(0, 0, 0, '0, 1, 3'd5, "R5 unknown");
      step(1, 1, 4'd5, ext_id(2), 0, 0, "R10 bind");
      step(1, 1, 4'd5, ext_id(0), 1, 3'd5, "R10 rebind");
      step(0, 0, 0, '0, 1, 3'd5, "R10 newest");
      step(0, 0, 0, '0, 0, 0, "R9 quiet");
      for (int i = 0; i < 4000; i++) begin
         int k = $urandom_range(0, 5);
         logic [ID_W-1:0] id = (k < NE) ? ext_id(k) : (k == 3 ? UNKNOWN_ID : INV);
         logic [3:0] sl = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(8, 15))
                                                      : 4'($urandom_range(0, 3));
         step($urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, sl, id,
              $urandom_range(0, 2) != 0, 3'($urandom_range(0, 3)), "R6 R2 random");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule